// File: doc/BRIEF.md
# Vectored interrupt arbitration unit

This unit picks the interrupt to service when the processor executes its vector-select instruction, and then fetches that interrupt's handler address. A one-cycle start strobe samples a software trap request and a set of maskable sources, each with a pending bit and an enable bit. The highest-ranked active source is turned into an even code byte between 0xE0 and 0xFE.

The unit keeps the upper byte of the current program counter and puts the code in the lower byte. This points into a vector table that sits in the same 256-byte page as the instruction. Two program-memory reads, one per cycle, return the high byte and then the low byte of the handler address. The unit then loads that address into its program-counter output and pulses done.

Top module: `vis_unit`

## Requirements
- R1: Every table address issued has a low byte that is even or even-plus-one and lies between 0xE0 and 0xFF. The code for a source of rank k (0 is highest) is 0xFE minus 2k.
- R2: While trap_i is high at start, the code is 0xFE, whatever the maskable inputs are.
- R3: Maskable input bit i has rank i+1. Bit 1 is the external interrupt, so with no trap and bit 1 as the highest active source the code is 0xFA. The lowest-numbered active bit wins.
- R4: A maskable source is active only when both its pend_i and en_i bits are 1. A source that is pending but disabled has no effect on the choice.
- R5: With no active source, the code is 0xE0.
- R6: The winner and the page are taken in the cycle start_i is accepted. Later changes to trap_i, pend_i, en_i or pc_i do not alter the fetch.
- R7: The first read (the cycle after start) has address {pc_i[15:8], code}. The second read (the next cycle) has address {pc_i[15:8], code+1}. mem_rd_o is high in exactly these two cycles.
- R8: On the edge after the second read, pc_o becomes {first byte read, second byte read}.
- R9: A start_i pulse during either read cycle is ignored.
- R10: done_o is high for exactly one cycle, the cycle in which pc_o first shows the new value. After reset, pc_o is 0 and done_o and mem_rd_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Vector-select strobe |
| trap_i | input | 1 | Software trap request, never masked |
| pend_i | input | N_MASK | Maskable pending bits |
| en_i | input | N_MASK | Maskable enable bits |
| pc_i | input | 16 | Current program counter |
| mem_addr_o | output | 16 | Program-memory read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid in the same cycle as the address |
| pc_o | output | 16 | Loaded program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a change to the sampled inputs after the choice has been made, combined with a second strobe arriving mid-fetch. Each run therefore scrambles trap, pending, enable and program-counter inputs right after the accepted strobe. It also holds start_i high through both read cycles. The addresses and the loaded value must still match the first sample. A sweep covers every rank alone, every rank with all lower ranks also pending, and pending-but-disabled sources, over several pages.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int BYTE_W   = 8;
  localparam int PC_W     = 2 * BYTE_W;
  localparam int RANK_W   = 4;
  localparam int MAX_MASK = (1 << RANK_W) - 2;
  localparam logic [BYTE_W-1:0] TOP_CODE = 8'hFE;

  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO} fetch_st_e;

  function automatic logic [BYTE_W-1:0] rank_code(input logic [RANK_W-1:0] r);
    return TOP_CODE - BYTE_W'({r, 1'b0});
  endfunction
endpackage

// File: rtl/vis_arbiter.sv
module vis_arbiter
  import vis_pkg::*;
#(
  parameter int N_MASK = 14
) (
  input  logic              trap_i,
  input  logic [N_MASK-1:0] pend_i,
  input  logic [N_MASK-1:0] en_i,
  output logic [RANK_W-1:0] rank_o
);
  logic [N_MASK-1:0] active;
  assign active = pend_i & en_i;

  always_comb begin
    rank_o = RANK_W'(MAX_MASK + 1);
    for (int i = N_MASK - 1; i >= 0; i--) begin
      if (active[i]) rank_o = RANK_W'(i + 1);
    end
    if (trap_i) rank_o = '0;
  end
endmodule

// File: rtl/vis_fetch.sv
module vis_fetch
  import vis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] code_i,
  input  logic [BYTE_W-1:0] page_i,
  output logic [PC_W-1:0]   mem_addr_o,
  output logic              mem_rd_o,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              done_o
);
  fetch_st_e         st_q;
  logic [BYTE_W-1:0] code_q, page_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
      page_q <= '0;
      hi_q   <= '0;
      pc_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          code_q <= code_i;
          page_q <= page_i;
          st_q   <= ST_HI;
        end
        ST_HI: begin
          hi_q <= mem_data_i;
          st_q <= ST_LO;
        end
        ST_LO: begin
          pc_o   <= {hi_q, mem_data_i};
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // second read sets the odd address inside the same code slot
  assign mem_rd_o   = (st_q != ST_IDLE);
  assign mem_addr_o = {page_q, code_q[BYTE_W-1:1], (st_q == ST_LO)};

  // R1
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_o[7:5] == 3'b111);
  // R7
  two_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_addr_o[0]) |=> (mem_rd_o && mem_addr_o[0]));
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_addr_o[0]) |=> !mem_rd_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_addr_o[0]) |=> done_o);
endmodule

// File: rtl/vis_unit.sv
module vis_unit
  import vis_pkg::*;
#(
  parameter int N_MASK = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              trap_i,
  input  logic [N_MASK-1:0] pend_i,
  input  logic [N_MASK-1:0] en_i,
  input  logic [15:0]       pc_i,
  output logic [15:0]       mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_data_i,
  output logic [15:0]       pc_o,
  output logic              done_o
);
  logic [RANK_W-1:0] rank;
  logic [BYTE_W-1:0] code;

  vis_arbiter #(.N_MASK(N_MASK)) u_arb (
    .trap_i (trap_i),
    .pend_i (pend_i),
    .en_i   (en_i),
    .rank_o (rank)
  );

  assign code = rank_code(rank);

  vis_fetch u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .code_i     (code),
    .page_i     (pc_i[PC_W-1:BYTE_W]),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_data_i (mem_data_i),
    .pc_o       (pc_o),
    .done_o     (done_o)
  );

  // R2
  trap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mem_rd_o && trap_i) |=> mem_addr_o[7:0] == 8'hFE);
  // R5
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mem_rd_o && !trap_i && ((pend_i & en_i) == '0)) |=> mem_addr_o[7:0] == 8'hE0);
endmodule

// File: tb/vis_unit_test.sv
`timescale 1ns/1ps
module vis_unit_test;
  localparam int N = 14;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trap = 1'b0;
  logic [N-1:0] pend = '0, en = '0;
  logic [15:0] pc_in = '0, mem_addr, pc_out;
  logic [7:0] mem_data;
  logic mem_rd, done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign mem_data = mem_addr[7:0] ^ {mem_addr[11:8], mem_addr[15:12]} ^ 8'h5A;

  vis_unit #(.N_MASK(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trap_i(trap),
    .pend_i(pend), .en_i(en), .pc_i(pc_in), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_data_i(mem_data), .pc_o(pc_out), .done_o(done)
  );

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one vector fetch with scrambling and ignored strobes (R6, R9)
  task automatic run(input logic t, input logic [N-1:0] p, input logic [N-1:0] e, input logic [15:0] pc);
    int rank;
    logic [7:0] code;
    logic [15:0] a0, a1, vec;
    rank = 15;
    for (int i = N - 1; i >= 0; i--) if (p[i] && e[i]) rank = i + 1;
    if (t) rank = 0;
    code = 8'hFE - 8'(2 * rank);
    a0 = {pc[15:8], code};
    a1 = {pc[15:8], code | 8'h01};
    vec = {mem_model(a0), mem_model(a1)};
    @(negedge clk);
    trap = t; pend = p; en = e; pc_in = pc; start = 1'b1;
    @(negedge clk);
    trap = ~t; pend = ~p; en = ~e; pc_in = ~pc;
    chk(mem_rd && mem_addr == a0, "R1/R2/R3/R4/R5/R7 first read", {15'd0, mem_rd, mem_addr}, {16'd1, a0});
    @(negedge clk);
    chk(mem_rd && mem_addr == a1, "R6/R7/R9 second read", {15'd0, mem_rd, mem_addr}, {16'd1, a1});
    @(negedge clk);
    start = 1'b0;
    chk(done && pc_out == vec, "R8/R10 load", {15'd0, done, pc_out}, {16'd1, vec});
    chk(!mem_rd, "R9 no restart", 32'(mem_rd), 32'd0);
    @(negedge clk);
    chk(!done && pc_out == vec, "R10 single pulse", {15'd0, done, pc_out}, {16'd0, vec});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pages [3];
    pages[0] = 16'h0012; pages[1] = 16'h3C77; pages[2] = 16'hFFE5;
    repeat (3) @(negedge clk);
    chk(pc_out == 16'h0 && !done && !mem_rd, "R10 reset", {14'd0, done, mem_rd, pc_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pg = 0; pg < 3; pg++) begin
      run(1'b1, '0, '0, pages[pg]);                 // R2 trap alone
      run(1'b1, '1, '1, pages[pg]);                 // R2 trap beats all
      run(1'b0, '0, '0, pages[pg]);                 // R5 none
      run(1'b0, '1, '0, pages[pg]);                 // R4 all masked
      run(1'b0, N'(2), N'(2), pages[pg]);           // R3 external -> 0xFA
      for (int i = 0; i < N; i++) begin
        logic [N-1:0] one, upper;
        one = N'(1) << i;
        upper = ~((one << 1) - N'(1));
        run(1'b0, one, one, pages[pg]);             // R1/R3 each rank alone
        run(1'b0, '1, one | upper, pages[pg]);      // R3 lowest index wins
        run(1'b0, one | ~one, ~one, pages[pg] ^ 16'(i)); // R4 pending but disabled bit i
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule